// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator

This block watches a running calendar clock held as eight BCD bytes (seconds, minutes, hours, date, month, year, day of week, century) and compares it with two independent alarm sets. Each alarm set has the same eight-byte layout as the clock. In every alarm byte, bit 7 is an enable for that field, and bits 6:0 hold the value to match. A field takes part in the comparison only when its enable is set. Bit 7 of each clock byte is never compared, so the 12/24-hour mode bit in the hour byte has no effect on a match.

The comparison is made only in the cycle where the once-per-second tick is high, using the clock bytes already advanced for that second. A match therefore fires exactly once per matching second. On a match, the block raises a one-cycle pulse for that alarm and sets a sticky status flag. The flag stays set until the status register is read. If only some fields are enabled, the alarm repeats: enabling month, date, hour, minute and second gives a yearly alarm.

Top module: `cal_alarm_match`

## Requirements
- R1: In the first cycle after a synchronous reset, both alarm flags and both alarm pulses are 0.
- R2: If `sec_tick` is high in cycle t, and every enabled field of alarm n equals the clock byte in bits 6:0, then `alarm_pulse[n]` is 1 in cycle t+1 only and `alarm_flag[n]` is 1 from cycle t+1.
- R3: A field whose enable bit (bit 7 of the alarm byte) is 0 has no effect on the match.
- R4: Bit 7 of every clock byte is left out of the comparison. This includes the 12/24-hour mode bit of the hour byte (byte index 2).
- R5: An alarm set with no enable bits set never pulses and never sets its flag.
- R6: When `sec_tick` is low, no match is evaluated. Neither a pulse nor a flag set occurs in the next cycle.
- R7: A set flag holds until `status_rd` is high, and it is 0 in the cycle after that read.
- R8: If a match and `status_rd` occur in the same cycle, the flag is 1 in the next cycle (the set takes priority).
- R9: The two alarm sets are evaluated independently. Alarm 0 uses bytes 0..7 of `alarm_bytes` and alarm 1 uses bytes 8..15.
- R10: With month, date, hour, minute and second enabled, the alarm fires whatever the year, day of week and century are. This gives a yearly repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, once per second, with the clock bytes already updated |
| time_bytes | input | 64 | Clock bytes, byte k at bits [8k+7:8k]: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 day of week, 7 century |
| alarm_bytes | input | 128 | Alarm n byte k at bits [64n+8k+7 : 64n+8k]; bit 7 is the enable, bits 6:0 are the value |
| status_rd | input | 1 | Status register read strobe; clears the flags |
| alarm_flag | output | 2 | Sticky alarm flags, one per alarm |
| alarm_pulse | output | 2 | One-cycle match pulse, one per alarm |

## Verification
The assertions check the cycle-level rules on every cycle: a pulse appears only after a tick, a pulse always comes with its flag, a flag holds unless status is read, a read with no tick clears the flag, and an alarm with no enables stays silent. Only the bench scenarios can show whether a match is actually correct. This covers per-field masking, the ignored bit 7 of the clock bytes, the yearly repeat, and the independence of the two alarm sets. The bench checks these against a reference model, using random clock values and partially matching alarm sets.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 8;
  localparam int NUM_ALARMS = 2;
  localparam int EN_BIT     = BYTE_W - 1;
  // compare value bits only; enable / mode bit excluded
  localparam logic [BYTE_W-1:0] CMP_MASK = {1'b0, {(BYTE_W-1){1'b1}}};
endpackage

// File: rtl/cal_field_cmp.sv
module cal_field_cmp
  import cal_alarm_pkg::*;
(
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic [BYTE_W-1:0] alm_byte,
  output logic              field_en,
  output logic              field_hit
);
  logic [BYTE_W-1:0] diff;

  always_comb begin
    diff      = (cur_byte ^ alm_byte) & CMP_MASK;
    field_en  = alm_byte[EN_BIT];
    field_hit = !field_en || (diff == '0);
  end
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int FIELDS = NUM_FIELDS,
  localparam int VEC_W = FIELDS * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_tick,
  input  logic             status_rd,
  input  logic [VEC_W-1:0] cur_vec,
  input  logic [VEC_W-1:0] alm_vec,
  output logic             flag,
  output logic             pulse
);
  logic [FIELDS-1:0] en_vec;
  logic [FIELDS-1:0] hit_vec;
  logic              fire;

  for (genvar k = 0; k < FIELDS; k++) begin : g_field
    cal_field_cmp u_cmp (
      .cur_byte (cur_vec[k*BYTE_W +: BYTE_W]),
      .alm_byte (alm_vec[k*BYTE_W +: BYTE_W]),
      .field_en (en_vec[k]),
      .field_hit(hit_vec[k])
    );
  end

  always_comb fire = sec_tick && (|en_vec) && (&hit_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= fire;
      if (fire)           flag <= 1'b1;
      else if (status_rd) flag <= 1'b0;
    end
  end

  p_pulse_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(sec_tick));
  p_pulse_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    pulse |-> flag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag && !status_rd) |=> flag);
  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !sec_tick) |=> !flag);
  p_no_enable_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (en_vec == '0) |=> !pulse);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  sec_tick,
  input  logic [NUM_FIELDS*BYTE_W-1:0]          time_bytes,
  input  logic [NUM_ALARMS*NUM_FIELDS*BYTE_W-1:0] alarm_bytes,
  input  logic                                  status_rd,
  output logic [NUM_ALARMS-1:0]                 alarm_flag,
  output logic [NUM_ALARMS-1:0]                 alarm_pulse
);
  localparam int SET_W = NUM_FIELDS * BYTE_W;

  for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_alarm
    cal_alarm_unit #(.FIELDS(NUM_FIELDS)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .sec_tick (sec_tick),
      .status_rd(status_rd),
      .cur_vec  (time_bytes),
      .alm_vec  (alarm_bytes[n*SET_W +: SET_W]),
      .flag     (alarm_flag[n]),
      .pulse    (alarm_pulse[n])
    );
  end

  p_pulse_onehot_window_r2: assert property (@(posedge clk) disable iff (rst)
    (alarm_pulse != '0) |=> ((alarm_pulse & $past(alarm_pulse)) == '0) || $past(sec_tick));
endmodule

// File: tb/cal_alarm_match_bench.sv
module cal_alarm_match_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         sec_tick;
  logic [63:0]  time_bytes;
  logic [127:0] alarm_bytes;
  logic         status_rd;
  logic [1:0]   alarm_flag;
  logic [1:0]   alarm_pulse;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_flag;
  logic [1:0] exp_pulse;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  cal_alarm_match u_cal_alarm_match (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .time_bytes(time_bytes),
    .alarm_bytes(alarm_bytes), .status_rd(status_rd),
    .alarm_flag(alarm_flag), .alarm_pulse(alarm_pulse));

  function automatic logic ref_match(logic [63:0] t, logic [63:0] a);
    logic any_en = 1'b0;
    logic ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (a[8*k+7]) begin
        any_en = 1'b1;
        if (t[8*k +: 7] != a[8*k +: 7]) ok = 1'b0;
      end
    end
    return any_en && ok;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive at negedge, model the edge, check at next negedge
  task automatic step(logic tick, logic rd, string req);
    logic [1:0] hit;
    sec_tick  = tick;
    status_rd = rd;
    for (int n = 0; n < 2; n++) begin
      hit[n] = tick && ref_match(time_bytes, alarm_bytes[64*n +: 64]);
      exp_pulse[n] = hit[n];
      if (hit[n]) exp_flag[n] = 1'b1;
      else if (rd) exp_flag[n] = 1'b0;
    end
    @(negedge clk);
    chk({req, " pulse"}, alarm_pulse, exp_pulse);
    chk({req, " flag"}, alarm_flag, exp_flag);
  endtask

  function automatic logic [63:0] mk_alarm(logic [63:0] t, logic [7:0] en);
    logic [63:0] a;
    for (int k = 0; k < 8; k++) a[8*k +: 8] = {en[k], t[8*k +: 7]};
    return a;
  endfunction

  initial begin
    rst = 1'b1; sec_tick = 0; status_rd = 0;
    time_bytes = '0; alarm_bytes = '0;
    exp_flag = '0; exp_pulse = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flag", alarm_flag, 2'b00);
    chk("R1 pulse", alarm_pulse, 2'b00);

    // R2 full match on alarm 0, R9 alarm 1 differs
    time_bytes = 64'h20_03_25_12_31_23_59_58;
    alarm_bytes[63:0]   = mk_alarm(time_bytes, 8'hFF);
    alarm_bytes[127:64] = mk_alarm(time_bytes ^ 64'h01, 8'hFF);
    step(1, 0, "R2 R9 match");
    step(0, 0, "R2 single pulse");
    // R6 no tick: flag unchanged, no pulse
    alarm_bytes[127:64] = mk_alarm(time_bytes, 8'hFF);
    step(0, 0, "R6 no tick");
    // R7 clear by read
    step(0, 1, "R7 clear");
    step(1, 0, "R9 both");
    // R8 set beats clear
    step(1, 1, "R8 set priority");
    step(0, 1, "R7 clear again");
    // R3 disabled field mismatch ignored
    alarm_bytes[63:0] = mk_alarm(time_bytes, 8'h0F) ^ 64'h00_00_7F_00_00_00_00_00;
    step(1, 1, "R3 masked field");
    // R4 hour bit7 in clock ignored
    time_bytes[23] = 1'b1;
    time_bytes[7]  = 1'b1;
    step(1, 1, "R4 mode bit");
    // R5 no enables
    alarm_bytes[63:0]   = mk_alarm(time_bytes, 8'h00);
    alarm_bytes[127:64] = mk_alarm(time_bytes, 8'h00);
    step(1, 1, "R5 no enable");
    step(1, 0, "R5 no enable again");
    // R10 yearly: fields 0..4 enabled, year/dow/century differ
    alarm_bytes[63:0] = mk_alarm(time_bytes, 8'h1F) ^ 64'h15_04_33_00_00_00_00_00;
    step(1, 1, "R10 yearly");
    time_bytes[63:40] = 24'h21_05_26;
    step(1, 1, "R10 next year");

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] t = {$urandom, $urandom};
      time_bytes = t;
      for (int n = 0; n < 2; n++) begin
        logic [63:0] a = mk_alarm(t, 8'($urandom));
        if ($urandom_range(1, 0) == 0) a = a ^ (64'h1 << $urandom_range(62, 0));
        alarm_bytes[64*n +: 64] = a;
      end
      step(($urandom_range(3, 0) != 0), ($urandom_range(3, 0) == 0), "R2 R3 R4 R7 R9 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule